// File: doc/BRIEF.md
# Privileged Control Register Bank with Return Sequencing

This block keeps the privileged control state of a 32-bit RISC core: the processor status word, the exception cause word, three return addresses (normal, error-level and debug), the translation high word with its address-space identifier, the hardware-register enable word, a load-linked flag and a debug-mode flag. Software reaches these through a single-cycle write port and a combinational read port. Each write is merged with the fields that software may change, and every other bit keeps its value or reads as zero.

The block also runs the privileged control operations. It performs the exception return and the debug return, which pick the return address and load the program counter. It performs the interrupt disable and interrupt enable, which swap the global interrupt enable bit and return the old status word. It checks user-mode reads of hardware registers and raises a reserved-instruction fault when they are not permitted. It also derives the user-mode flag from the current status and debug state. When a write changes the address-space identifier, it emits a one-cycle flush pulse for the translation cache.

Top module: `sysctl_regfile`

## Requirements
- R1: After reset the status word reads 0x00000004 (error level set), every other register, both flags and all outputs read zero, and user mode is deasserted.
- R2: A status write stores the written value ANDed with 0xF878FF17. Status bit 0 is interrupt enable, bit 1 exception level, bit 2 error level, bit 4 user mode and bit 28 the coprocessor-0 usable bit.
- R3: A cause write changes only bits 8, 9, 22 and 23 (mask 0x00C00300), and all other cause bits keep their value.
- R4: An address-space write stores the value with bits 12:8 forced to zero. In the cycle after the write, the flush output pulses high for one cycle if and only if bits 7:0 differ from their old value.
- R5: Register selects are 0 status, 1 cause, 2 return address, 3 error return address, 4 debug return address, 5 address-space word, 6 hardware enable, 7 flag word. Registers 2 to 4 store all 32 bits. The hardware enable keeps only mask 0xC000000F. The flag word holds the load-linked flag in bit 0 and debug mode in bit 1.
- R6: Operation codes are 0 exception return, 1 debug return, 2 interrupt disable, 3 interrupt enable and 4 hardware-register read. An exception return with the error level set loads the PC from the error return address and clears the error level. Otherwise it loads the PC from the return address and clears the exception level. The PC-load output pulses in the next cycle.
- R7: A debug return loads the PC from the debug return address and sets debug mode.
- R8: Both return operations set the load-linked flag.
- R9: User mode is asserted exactly when exception level, error level and debug mode are all clear and the status user bit is set.
- R10: Interrupt disable and interrupt enable place the old status word on the result output in the next cycle, and they clear or set status bit 0.
- R11: A hardware-register read of index 0, 1, 2, 3, 30 or 31 is allowed outside user mode, when the hardware enable bit with that index is set, or when status bit 28 is set. A denied or unimplemented index pulses the fault output for one cycle and leaves the result output unchanged.
- R12: Hardware register 0 returns the processor-number input, 1 the cache-line step parameter, 2 the cycle-count input and 3 the count-resolution parameter. Registers 30 and 31 return zero.
- R13: A register write issued in the same cycle as an operation is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 3 | Register select for a write |
| wr_data_i | input | 32 | Write data |
| rd_sel_i | input | 3 | Register select for a read |
| rd_data_o | output | 32 | Read data, combinational |
| op_valid_i | input | 1 | Operation strobe |
| op_code_i | input | 3 | Operation code |
| hwr_idx_i | input | 5 | Hardware-register index for a read operation |
| cpunum_i | input | 10 | Processor number from the exception-base register |
| cycle_cnt_i | input | 32 | Current cycle count |
| pc_load_o | output | 1 | One-cycle pulse: load new_pc_o |
| new_pc_o | output | 32 | Return target of the last return operation |
| op_result_o | output | 32 | Old status or hardware-register value |
| ri_fault_o | output | 1 | One-cycle reserved-instruction fault |
| asid_flush_o | output | 1 | One-cycle translation flush request |
| user_mode_o | output | 1 | Core is in user mode |

## Verification
The hardest condition to reach is a hardware-register read issued from user mode. Reset leaves the error level set, so the core starts in kernel mode. A read is then denied only after a status write has cleared both levels and set the user bit, with debug mode also clear. The directed stimulus builds that state on purpose and then walks the hardware enable bit and the coprocessor-usable bit through grant and deny. The seeded random phase mixes status, flag-word and enable writes with reads, so it moves in and out of user mode many times.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;
   localparam int XLEN = 32;

   typedef enum logic [2:0] {
      SEL_STATUS  = 3'd0,
      SEL_CAUSE   = 3'd1,
      SEL_EPC     = 3'd2,
      SEL_ERREPC  = 3'd3,
      SEL_DEPC    = 3'd4,
      SEL_ENTRYHI = 3'd5,
      SEL_HWRENA  = 3'd6,
      SEL_FLAGS   = 3'd7
   } csr_sel_t;

   typedef enum logic [2:0] {
      OP_ERET  = 3'd0,
      OP_DERET = 3'd1,
      OP_DI    = 3'd2,
      OP_EI    = 3'd3,
      OP_RDHWR = 3'd4
   } ctl_op_t;

   localparam int ST_IE  = 0;
   localparam int ST_EXL = 1;
   localparam int ST_ERL = 2;
   localparam int ST_UM  = 4;
   localparam int ST_CU0 = 28;

   typedef struct packed {
      logic [XLEN-1:0] status;
      logic [XLEN-1:0] cause;
      logic [XLEN-1:0] epc;
      logic [XLEN-1:0] errepc;
      logic [XLEN-1:0] depc;
      logic [XLEN-1:0] entryhi;
      logic [XLEN-1:0] hwrena;
      logic            ll;
      logic            dm;
   } csr_state_t;
endpackage

// File: rtl/sysctl_csr_bank.sv
module sysctl_csr_bank
   import sysctl_pkg::*;
#(
   parameter logic [XLEN-1:0] STATUS_WMASK = 32'hF878FF17,
   parameter logic [XLEN-1:0] CAUSE_WMASK  = 32'h00C00300,
   parameter logic [XLEN-1:0] HWRENA_WMASK = 32'hC000000F,
   parameter logic [XLEN-1:0] EHI_CLEAR    = 32'h00001F00,
   parameter int              ASID_W       = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr_en,
   input  logic [2:0]      wr_sel,
   input  logic [XLEN-1:0] wr_data,
   input  logic            op_valid,
   input  logic [2:0]      op_code,
   output csr_state_t      st,
   output logic            asid_chg
);
   localparam int NUM_RET  = 3;
   localparam int RET_BASE = int'(SEL_EPC);

   logic            wr_go;
   logic [XLEN-1:0] status_q, cause_q, entryhi_q, hwrena_q;
   logic            ll_q, dm_q;

   assign wr_go = wr_en && !op_valid;

   // return-address registers: identical full-width slots at consecutive selects
   for (genvar g = 0; g < NUM_RET; g++) begin : g_ret
      logic [XLEN-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            q <= '0;
         else if (wr_go && (wr_sel == 3'(RET_BASE + g)))
            q <= wr_data;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         status_q  <= XLEN'(1) << ST_ERL;
         cause_q   <= '0;
         entryhi_q <= '0;
         hwrena_q  <= '0;
         ll_q      <= 1'b0;
         dm_q      <= 1'b0;
      end else if (op_valid) begin
         case (ctl_op_t'(op_code))
            OP_ERET: begin
               if (status_q[ST_ERL]) status_q[ST_ERL] <= 1'b0;
               else                  status_q[ST_EXL] <= 1'b0;
               ll_q <= 1'b1;
            end
            OP_DERET: begin
               dm_q <= 1'b1;
               ll_q <= 1'b1;
            end
            OP_DI:   status_q[ST_IE] <= 1'b0;
            OP_EI:   status_q[ST_IE] <= 1'b1;
            default: ;
         endcase
      end else if (wr_en) begin
         case (csr_sel_t'(wr_sel))
            SEL_STATUS:  status_q  <= wr_data & STATUS_WMASK;
            SEL_CAUSE:   cause_q   <= (cause_q & ~CAUSE_WMASK) | (wr_data & CAUSE_WMASK);
            SEL_ENTRYHI: entryhi_q <= wr_data & ~EHI_CLEAR;
            SEL_HWRENA:  hwrena_q  <= wr_data & HWRENA_WMASK;
            SEL_FLAGS: begin
               ll_q <= wr_data[0];
               dm_q <= wr_data[1];
            end
            default: ;
         endcase
      end
   end

   assign asid_chg = wr_go && (csr_sel_t'(wr_sel) == SEL_ENTRYHI) &&
                     (wr_data[ASID_W-1:0] != entryhi_q[ASID_W-1:0]);

   always_comb begin
      st.status  = status_q;
      st.cause   = cause_q;
      st.epc     = g_ret[0].q;
      st.errepc  = g_ret[1].q;
      st.depc    = g_ret[2].q;
      st.entryhi = entryhi_q;
      st.hwrena  = hwrena_q;
      st.ll      = ll_q;
      st.dm      = dm_q;
   end

   // R3: bits outside the cause write mask never move on a cause write
   a_r3_cause_keep: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_go && csr_sel_t'(wr_sel) == SEL_CAUSE) |=>
      (((cause_q ^ $past(cause_q)) & ~CAUSE_WMASK) == '0));

   // R13: a write colliding with an operation leaves the address-space word alone
   a_r13_collide: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && op_valid) |=> $stable(entryhi_q) && $stable(hwrena_q));
endmodule

// File: rtl/sysctl_mode.sv
module sysctl_mode (
   input  logic exl,
   input  logic erl,
   input  logic dm,
   input  logic um,
   output logic user_mode
);
   assign user_mode = um && !exl && !erl && !dm;
endmodule

// File: rtl/sysctl_hwr_gate.sv
module sysctl_hwr_gate
   import sysctl_pkg::*;
#(
   parameter int              IDX_W      = 5,
   parameter int              CPUNUM_W   = 10,
   parameter logic [XLEN-1:0] SYNCI_STEP = 32'd32,
   parameter logic [XLEN-1:0] CC_RES     = 32'd1
) (
   input  logic [IDX_W-1:0]    idx,
   input  logic                user_mode,
   input  logic [XLEN-1:0]     hwrena,
   input  logic                cu0,
   input  logic [CPUNUM_W-1:0] cpunum,
   input  logic [XLEN-1:0]     cycle_cnt,
   output logic                granted,
   output logic [XLEN-1:0]     value
);
   logic implemented;

   always_comb begin
      implemented = 1'b1;
      value       = '0;
      case (idx)
         IDX_W'(0):  value = XLEN'(cpunum);
         IDX_W'(1):  value = SYNCI_STEP;
         IDX_W'(2):  value = cycle_cnt;
         IDX_W'(3):  value = CC_RES;
         IDX_W'(30), IDX_W'(31): value = '0;
         default:    implemented = 1'b0;
      endcase
   end

   assign granted = implemented && (!user_mode || hwrena[idx] || cu0);
endmodule

// File: rtl/sysctl_regfile.sv
module sysctl_regfile
   import sysctl_pkg::*;
#(
   parameter logic [31:0] STATUS_WMASK = 32'hF878FF17,
   parameter logic [31:0] CAUSE_WMASK  = 32'h00C00300,
   parameter logic [31:0] HWRENA_WMASK = 32'hC000000F,
   parameter logic [31:0] EHI_CLEAR    = 32'h00001F00,
   parameter int          ASID_W       = 8,
   parameter int          HWR_IDX_W    = 5,
   parameter int          CPUNUM_W     = 10,
   parameter logic [31:0] SYNCI_STEP   = 32'd32,
   parameter logic [31:0] CC_RES       = 32'd1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en_i,
   input  logic [2:0]          wr_sel_i,
   input  logic [31:0]         wr_data_i,
   input  logic [2:0]          rd_sel_i,
   output logic [31:0]         rd_data_o,
   input  logic                op_valid_i,
   input  logic [2:0]          op_code_i,
   input  logic [HWR_IDX_W-1:0] hwr_idx_i,
   input  logic [CPUNUM_W-1:0] cpunum_i,
   input  logic [31:0]         cycle_cnt_i,
   output logic                pc_load_o,
   output logic [31:0]         new_pc_o,
   output logic [31:0]         op_result_o,
   output logic                ri_fault_o,
   output logic                asid_flush_o,
   output logic                user_mode_o
);
   if (ASID_W < 1 || ASID_W > 8) begin : g_bad_asid
      $error("ASID_W must lie in 1..8");
   end
   if (HWR_IDX_W != 5) begin : g_bad_idx
      $error("HWR_IDX_W must be 5 to index a 32-bit enable word");
   end
   if (CPUNUM_W < 1 || CPUNUM_W > XLEN) begin : g_bad_cpunum
      $error("CPUNUM_W must lie in 1..XLEN");
   end

   csr_state_t  st;
   logic        asid_chg, hwr_ok;
   logic [31:0] hwr_val;

   sysctl_csr_bank #(
      .STATUS_WMASK(STATUS_WMASK), .CAUSE_WMASK(CAUSE_WMASK),
      .HWRENA_WMASK(HWRENA_WMASK), .EHI_CLEAR(EHI_CLEAR), .ASID_W(ASID_W)
   ) u_bank (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en_i), .wr_sel(wr_sel_i),
      .wr_data(wr_data_i), .op_valid(op_valid_i), .op_code(op_code_i),
      .st(st), .asid_chg(asid_chg)
   );

   sysctl_mode u_mode (
      .exl(st.status[ST_EXL]), .erl(st.status[ST_ERL]), .dm(st.dm),
      .um(st.status[ST_UM]), .user_mode(user_mode_o)
   );

   sysctl_hwr_gate #(
      .IDX_W(HWR_IDX_W), .CPUNUM_W(CPUNUM_W),
      .SYNCI_STEP(SYNCI_STEP), .CC_RES(CC_RES)
   ) u_gate (
      .idx(hwr_idx_i), .user_mode(user_mode_o), .hwrena(st.hwrena),
      .cu0(st.status[ST_CU0]), .cpunum(cpunum_i), .cycle_cnt(cycle_cnt_i),
      .granted(hwr_ok), .value(hwr_val)
   );

   always_comb begin
      case (csr_sel_t'(rd_sel_i))
         SEL_STATUS:  rd_data_o = st.status;
         SEL_CAUSE:   rd_data_o = st.cause;
         SEL_EPC:     rd_data_o = st.epc;
         SEL_ERREPC:  rd_data_o = st.errepc;
         SEL_DEPC:    rd_data_o = st.depc;
         SEL_ENTRYHI: rd_data_o = st.entryhi;
         SEL_HWRENA:  rd_data_o = st.hwrena;
         default:     rd_data_o = {30'd0, st.dm, st.ll};
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pc_load_o    <= 1'b0;
         new_pc_o     <= '0;
         op_result_o  <= '0;
         ri_fault_o   <= 1'b0;
         asid_flush_o <= 1'b0;
      end else begin
         pc_load_o    <= 1'b0;
         ri_fault_o   <= 1'b0;
         asid_flush_o <= asid_chg;
         if (op_valid_i) begin
            case (ctl_op_t'(op_code_i))
               OP_ERET: begin
                  pc_load_o <= 1'b1;
                  new_pc_o  <= st.status[ST_ERL] ? st.errepc : st.epc;
               end
               OP_DERET: begin
                  pc_load_o <= 1'b1;
                  new_pc_o  <= st.depc;
               end
               OP_DI, OP_EI: op_result_o <= st.status;
               OP_RDHWR: begin
                  if (hwr_ok) op_result_o <= hwr_val;
                  else        ri_fault_o  <= 1'b1;
               end
               default: ;
            endcase
         end
      end
   end

   // R6: error-level return goes to the error return address and drops the level
   a_r6_eret_erl: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid_i && ctl_op_t'(op_code_i) == OP_ERET && st.status[ST_ERL]) |=>
      (pc_load_o && new_pc_o == $past(st.errepc) && !st.status[ST_ERL]));

   // R6: ordinary return goes to the return address and drops the exception level
   a_r6_eret_exl: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid_i && ctl_op_t'(op_code_i) == OP_ERET && !st.status[ST_ERL]) |=>
      (pc_load_o && new_pc_o == $past(st.epc) && !st.status[ST_EXL]));

   // R7: debug return
   a_r7_deret: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid_i && ctl_op_t'(op_code_i) == OP_DERET) |=>
      (pc_load_o && new_pc_o == $past(st.depc) && st.dm));

   // R8: both returns leave the load-linked flag set
   a_r8_ll_set: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid_i && (ctl_op_t'(op_code_i) == OP_ERET || ctl_op_t'(op_code_i) == OP_DERET))
      |=> st.ll);

   // R11: a fault only follows a hardware-register read
   a_r11_fault_src: assert property (@(posedge clk) disable iff (!rst_n)
      ri_fault_o |-> $past(op_valid_i && ctl_op_t'(op_code_i) == OP_RDHWR));

   // R4: a flush only follows an accepted address-space write
   a_r4_flush_src: assert property (@(posedge clk) disable iff (!rst_n)
      asid_flush_o |-> $past(wr_en_i && !op_valid_i && csr_sel_t'(wr_sel_i) == SEL_ENTRYHI));

   // R10: interrupt enable leaves bit 0 set and reports the prior word
   a_r10_ei: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid_i && ctl_op_t'(op_code_i) == OP_EI) |=>
      (st.status[ST_IE] && op_result_o == $past(st.status)));
endmodule

// File: tb/sysctl_regfile_tb.sv
`timescale 1ns/100ps
module sysctl_regfile_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [2:0]  wr_sel = '0;
   logic [31:0] wr_data = '0;
   logic [2:0]  rd_sel = '0;
   logic [31:0] rd_data;
   logic        op_valid = 1'b0;
   logic [2:0]  op_code = '0;
   logic [4:0]  hwr_idx = '0;
   logic [9:0]  cpunum = 10'h2BC;
   logic [31:0] cycle_cnt = '0;
   logic        pc_load, ri_fault, asid_flush, user_mode;
   logic [31:0] new_pc, op_result;

   int n_chk = 0;
   int n_err = 0;

   // model state
   logic [31:0] m_reg [8];
   logic [31:0] m_pc, m_res;
   logic        m_pcl, m_ri, m_fl;

   always #5 clk = ~clk;

   sysctl_regfile u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_sel_i(wr_sel),
      .wr_data_i(wr_data), .rd_sel_i(rd_sel), .rd_data_o(rd_data),
      .op_valid_i(op_valid), .op_code_i(op_code), .hwr_idx_i(hwr_idx),
      .cpunum_i(cpunum), .cycle_cnt_i(cycle_cnt), .pc_load_o(pc_load),
      .new_pc_o(new_pc), .op_result_o(op_result), .ri_fault_o(ri_fault),
      .asid_flush_o(asid_flush), .user_mode_o(user_mode)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   function automatic logic exp_user();
      return m_reg[0][4] && !m_reg[0][1] && !m_reg[0][2] && !m_reg[7][1];
   endfunction

   function automatic logic [31:0] exp_hwr(input logic [4:0] idx, output logic ok);
      logic impl;
      logic [31:0] v;
      impl = 1'b1;
      case (idx)
         5'd0: v = {22'd0, cpunum};
         5'd1: v = 32'd32;
         5'd2: v = cycle_cnt;
         5'd3: v = 32'd1;
         5'd30, 5'd31: v = 32'd0;
         default: begin v = 32'd0; impl = 1'b0; end
      endcase
      ok = impl && (!exp_user() || m_reg[6][idx] || m_reg[0][28]);
      return v;
   endfunction

   function automatic string sel_tag(input int s);
      case (s)
         0: return "R2 status";
         1: return "R3 cause";
         5: return "R4 addrspace";
         7: return "R8 flags";
         default: return "R5 reg";
      endcase
   endfunction

   task automatic readall();
      for (int s = 0; s < 8; s++) begin
         rd_sel = 3'(s);
         #0.2;
         chk(sel_tag(s), rd_data, m_reg[s]);
      end
   endtask

   task automatic step(input logic we, input logic [2:0] sel, input logic [31:0] d,
                       input logic ov, input logic [2:0] code, input logic [4:0] idx);
      logic ok;
      logic [31:0] v;
      wr_en = we; wr_sel = sel; wr_data = d;
      op_valid = ov; op_code = code; hwr_idx = idx;
      m_pcl = 1'b0; m_ri = 1'b0; m_fl = 1'b0;
      if (ov) begin
         case (code)
            3'd0: begin
               m_pcl = 1'b1;
               if (m_reg[0][2]) begin m_pc = m_reg[3]; m_reg[0][2] = 1'b0; end
               else begin m_pc = m_reg[2]; m_reg[0][1] = 1'b0; end
               m_reg[7][0] = 1'b1;
            end
            3'd1: begin
               m_pcl = 1'b1; m_pc = m_reg[4];
               m_reg[7][1] = 1'b1; m_reg[7][0] = 1'b1;
            end
            3'd2: begin m_res = m_reg[0]; m_reg[0][0] = 1'b0; end
            3'd3: begin m_res = m_reg[0]; m_reg[0][0] = 1'b1; end
            3'd4: begin
               v = exp_hwr(idx, ok);
               if (ok) m_res = v; else m_ri = 1'b1;
            end
            default: ;
         endcase
      end else if (we) begin
         case (sel)
            3'd0: m_reg[0] = d & 32'hF878FF17;
            3'd1: m_reg[1] = (m_reg[1] & ~32'h00C00300) | (d & 32'h00C00300);
            3'd5: begin
               m_fl = (d[7:0] != m_reg[5][7:0]);
               m_reg[5] = d & ~32'h00001F00;
            end
            3'd6: m_reg[6] = d & 32'hC000000F;
            3'd7: m_reg[7] = {30'd0, d[1:0]};
            default: m_reg[sel] = d;
         endcase
      end
      @(posedge clk);
      @(negedge clk);
      wr_en = 1'b0; op_valid = 1'b0;
      #0.1;
      chk((ov && code == 3'd1) ? "R7 pc_load" : "R6 pc_load", 32'(pc_load), 32'(m_pcl));
      chk((ov && code == 3'd1) ? "R7 new_pc" : "R6 new_pc", new_pc, m_pc);
      chk((ov && code == 3'd4) ? "R12 result" : "R10 result", op_result, m_res);
      chk("R11 fault", 32'(ri_fault), 32'(m_ri));
      chk("R4 flush", 32'(asid_flush), 32'(m_fl));
      chk("R9 user_mode", 32'(user_mode), 32'(exp_user()));
      readall();
   endtask

   initial begin
      #1_000_000;
      n_err++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

   initial begin
      for (int i = 0; i < 8; i++) m_reg[i] = '0;
      m_reg[0] = 32'h4;
      m_pc = '0; m_res = '0;
      void'($urandom(32'd4711));
      repeat (3) @(negedge clk);
      #0.1;
      // R1: reset state
      chk("R1 pc_load", 32'(pc_load), 0);
      chk("R1 new_pc", new_pc, 0);
      chk("R1 result", op_result, 0);
      chk("R1 fault", 32'(ri_fault | asid_flush), 0);
      chk("R1 user_mode", 32'(user_mode), 0);
      for (int s = 0; s < 8; s++) begin
         rd_sel = 3'(s); #0.2;
         chk("R1 reset value", rd_data, s == 0 ? 32'h4 : 32'h0);
      end
      rst_n = 1'b1;
      @(negedge clk);

      // R6: return at error level, then at exception level
      step(1, 3'd3, 32'h1234_5678, 0, 0, 0);
      step(1, 3'd2, 32'hAAAA_0000, 0, 0, 0);
      step(0, 0, 0, 1, 3'd0, 0);
      step(1, 3'd0, 32'h0000_0002, 0, 0, 0);
      step(0, 0, 0, 1, 3'd0, 0);
      // R7: debug return
      step(1, 3'd4, 32'hBEEF_0004, 0, 0, 0);
      step(0, 0, 0, 1, 3'd1, 0);
      // R2 mask, R3 cause merge, R5 widths
      step(1, 3'd0, 32'hFFFF_FFFF, 0, 0, 0);
      step(1, 3'd1, 32'hFFFF_FFFF, 0, 0, 0);
      step(1, 3'd1, 32'h0000_0000, 0, 0, 0);
      step(1, 3'd6, 32'hFFFF_FFFF, 0, 0, 0);
      // R10: disable then enable
      step(0, 0, 0, 1, 3'd2, 0);
      step(0, 0, 0, 1, 3'd3, 0);
      // R9/R11: enter user mode and probe hardware reads
      step(1, 3'd6, 32'h0, 0, 0, 0);
      step(1, 3'd7, 32'h0, 0, 0, 0);
      step(1, 3'd0, 32'h0000_0010, 0, 0, 0);
      cycle_cnt = 32'h0000_9ABC;
      step(0, 0, 0, 1, 3'd4, 5'd2);
      step(1, 3'd6, 32'h0000_0004, 0, 0, 0);
      step(0, 0, 0, 1, 3'd4, 5'd2);
      step(0, 0, 0, 1, 3'd4, 5'd0);
      step(1, 3'd0, 32'h1000_0010, 0, 0, 0);
      step(0, 0, 0, 1, 3'd4, 5'd1);
      step(0, 0, 0, 1, 3'd4, 5'd30);
      step(0, 0, 0, 1, 3'd4, 5'd9);
      step(1, 3'd6, 32'h8000_0000, 0, 0, 0);
      step(1, 3'd0, 32'h0000_0010, 0, 0, 0);
      step(0, 0, 0, 1, 3'd4, 5'd31);
      step(0, 0, 0, 1, 3'd4, 5'd3);
      // R12: kernel-mode read of register 0
      step(1, 3'd0, 32'h0, 0, 0, 0);
      step(0, 0, 0, 1, 3'd4, 5'd0);
      // R4: address-space writes with changed and unchanged identifiers
      step(1, 3'd5, 32'hFFFF_FF5A, 0, 0, 0);
      step(1, 3'd5, 32'h1234_005A, 0, 0, 0);
      step(1, 3'd5, 32'h1234_0001, 0, 0, 0);
      // R13: write collides with an operation and must be dropped
      step(1, 3'd5, 32'h0000_00FF, 1, 3'd2, 0);
      rd_sel = 3'd5; #0.2;
      chk("R13 collided write dropped", rd_data, 32'h1234_0001);
      chk("R13 no flush", 32'(asid_flush), 0);

      for (int n = 0; n < 600; n++) begin
         logic [4:0] ix;
         case ($urandom % 8)
            0: ix = 5'd0; 1: ix = 5'd1; 2: ix = 5'd2; 3: ix = 5'd3;
            4: ix = 5'd30; 5: ix = 5'd31; 6: ix = 5'd5; default: ix = 5'd17;
         endcase
         cycle_cnt = $urandom;
         step(($urandom % 4) != 0, 3'($urandom % 8), $urandom,
              ($urandom % 10) < 3, 3'($urandom % 5), ix);
      end

      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end
endmodule